// File: doc/BRIEF.md
# Conditional Jump Resolver

This combinational block settles, for a 16-bit processor, whether a relative jump instruction is taken and what the program counter becomes next. It receives the program counter already advanced past the jump word, a 3-bit condition selector, a 10-bit signed word offset and the four status flags: carry, zero, negative and overflow. It returns a taken strobe and the next program counter. Both outputs follow the inputs in the same cycle, with no register in the path.

A taken jump lands at the advanced counter plus twice the sign-extended offset. A jump that is not taken falls through to the advanced counter. The counter addresses 16-bit words, so bit 0 of the result is always cleared. Instruction fetch, decoding of other formats and register-indirect branches belong to other blocks.

Top module: `jump_resolver`

## Requirements
- R1: Selector 3 is taken exactly when the carry flag is 1, and selector 2 is taken exactly when the carry flag is 0.
- R2: Selector 1 is taken exactly when the zero flag is 1, and selector 0 is taken exactly when the zero flag is 0.
- R3: Selector 4 is taken exactly when the negative flag is 1.
- R4: Selector 5 (signed greater-or-equal) is taken when negative XOR overflow is 0, and selector 6 (signed less) is taken when it is 1.
- R5: Selector 7 is always taken, whatever the flags hold.
- R6: When taken, the next PC equals the advanced PC (bit 0 cleared) plus two times the sign-extended offset, modulo 2^16.
- R7: When not taken, the next PC equals the advanced PC with bit 0 cleared.
- R8: Bit 0 of the next PC is 0 for every input, including an advanced PC with bit 0 set.
- R9: The offset extremes -512 and +511 words give displacements of -1024 and +1022 bytes, and the sum wraps around the 16-bit address space.
- R10: Both outputs respond to an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_in | input | 16 | Program counter already advanced past the jump word |
| cond_in | input | 3 | Condition selector, codes as in R1 to R5 |
| ofs_in | input | 10 | Signed jump distance in words |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| take_o | output | 1 | High when the jump is taken |
| next_pc_o | output | 16 | Program counter to fetch from next |

## Verification
The assertions are immediate checks on combinational values. They assume that the inputs hold steady long enough for the logic to settle, and that they carry no unknown bits. The bench drives every input with a known value straight after a clock edge and reads the outputs at the falling edge. The one exception is the check of R10, which changes the inputs between edges and waits a short delay before reading the outputs.

// File: rtl/jres_pkg.sv
package jres_pkg;

  typedef enum logic [2:0] {
    JC_ZCLR   = 3'd0,
    JC_ZSET   = 3'd1,
    JC_CCLR   = 3'd2,
    JC_CSET   = 3'd3,
    JC_NEG    = 3'd4,
    JC_GE     = 3'd5,
    JC_LT     = 3'd6,
    JC_ALWAYS = 3'd7
  } jcond_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } jflags_t;

  // Decide whether one condition code holds for a given flag set.
  function automatic logic cond_met(input jcond_e code, input jflags_t f);
    logic r;
    case (code)
      JC_ZCLR:   r = ~f.z;
      JC_ZSET:   r = f.z;
      JC_CCLR:   r = ~f.c;
      JC_CSET:   r = f.c;
      JC_NEG:    r = f.n;
      JC_GE:     r = ~(f.n ^ f.v);
      JC_LT:     r = f.n ^ f.v;
      default:   r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/jres_cond_eval.sv
module jres_cond_eval
  import jres_pkg::*;
#(
  parameter int COND_W = 3
) (
  input  jflags_t             flags,
  input  logic [COND_W-1:0]   sel,
  output logic                hit
);
  localparam int NCOND = 1 << COND_W;

  logic [NCOND-1:0] hit_vec;

  // One evaluator per selector code; the selector then picks one.
  for (genvar g = 0; g < NCOND; g++) begin : g_code
    assign hit_vec[g] = cond_met(jcond_e'(3'(g)), flags);
  end

  assign hit = hit_vec[sel];
endmodule

// File: rtl/jres_target.sv
module jres_target #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 10
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] ofs,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  tgt_pc
);
  localparam int EXT_W = PC_W - OFS_W - 1;

  // Word offset turned into a byte displacement of full PC width.
  function automatic logic [PC_W-1:0] byte_disp(input logic [OFS_W-1:0] o);
    return {{EXT_W{o[OFS_W-1]}}, o, 1'b0};
  endfunction

  function automatic logic [PC_W-1:0] word_align(input logic [PC_W-1:0] p);
    return {p[PC_W-1:1], 1'b0};
  endfunction

  assign seq_pc = word_align(pc);
  assign tgt_pc = seq_pc + byte_disp(ofs);
endmodule

// File: rtl/jres_select.sv
module jres_select #(
  parameter int PC_W = 16
) (
  input  logic            take,
  input  logic [PC_W-1:0] seq_pc,
  input  logic [PC_W-1:0] tgt_pc,
  output logic [PC_W-1:0] next_pc
);
  always_comb begin
    if (take) next_pc = tgt_pc;
    else      next_pc = seq_pc;
  end
endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
  import jres_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int OFS_W  = 10,
  parameter int COND_W = 3
) (
  input  logic [PC_W-1:0]   pc_in,
  input  logic [COND_W-1:0] cond_in,
  input  logic [OFS_W-1:0]  ofs_in,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              flag_v,
  output logic              take_o,
  output logic [PC_W-1:0]   next_pc_o
);
  jflags_t          flags;
  logic             cond_hit;
  logic [PC_W-1:0]  seq_pc;
  logic [PC_W-1:0]  tgt_pc;

  assign flags = '{c: flag_c, z: flag_z, n: flag_n, v: flag_v};

  jres_cond_eval #(.COND_W(COND_W)) u_eval (
    .flags (flags),
    .sel   (cond_in),
    .hit   (cond_hit)
  );

  jres_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_tgt (
    .pc     (pc_in),
    .ofs    (ofs_in),
    .seq_pc (seq_pc),
    .tgt_pc (tgt_pc)
  );

  jres_select #(.PC_W(PC_W)) u_sel (
    .take    (cond_hit),
    .seq_pc  (seq_pc),
    .tgt_pc  (tgt_pc),
    .next_pc (next_pc_o)
  );

  assign take_o = cond_hit;
endmodule

// File: rtl/jump_resolver_chk.sv
module jump_resolver_chk #(
  parameter int PC_W   = 16,
  parameter int COND_W = 3
) (
  input logic [PC_W-1:0]   pc_in,
  input logic [COND_W-1:0] cond_in,
  input logic              flag_c,
  input logic              flag_n,
  input logic              flag_v,
  input logic              take_o,
  input logic [PC_W-1:0]   next_pc_o,
  input logic [PC_W-1:0]   tgt_pc
);
  always_comb begin
    if (!$isunknown({cond_in, flag_c, flag_n, flag_v, pc_in})) begin
      a_r1_carry_set: assert (cond_in != 3'd3 || take_o == flag_c);
      a_r4_ge_sense: assert (cond_in != 3'd5 || take_o == (flag_n ~^ flag_v));
      a_r5_always_taken: assert (cond_in != 3'd7 || take_o);
      a_r6_taken_target: assert (!take_o || next_pc_o == tgt_pc);
      a_r7_fall_through: assert (take_o || next_pc_o == {pc_in[PC_W-1:1], 1'b0});
      a_r8_word_aligned: assert (next_pc_o[0] == 1'b0);
    end
  end
endmodule

bind jump_resolver jump_resolver_chk #(.PC_W(PC_W), .COND_W(COND_W)) u_chk (
  .pc_in     (pc_in),
  .cond_in   (cond_in),
  .flag_c    (flag_c),
  .flag_n    (flag_n),
  .flag_v    (flag_v),
  .take_o    (take_o),
  .next_pc_o (next_pc_o),
  .tgt_pc    (tgt_pc)
);

// File: tb/jump_resolver_tb.sv
module jump_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pc_in = '0;
  logic [2:0]  cond_in = '0;
  logic [9:0]  ofs_in = '0;
  logic        flag_c = 0, flag_z = 0, flag_n = 0, flag_v = 0;
  logic        take_o;
  logic [15:0] next_pc_o;
  int          n_checks = 0;
  int          n_errors = 0;

  always #5 clk = ~clk;

  jump_resolver u_dut (
    .pc_in(pc_in), .cond_in(cond_in), .ofs_in(ofs_in),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
    .take_o(take_o), .next_pc_o(next_pc_o)
  );

  function automatic bit model_take(input logic [2:0] k, input logic c, z, n, v);
    case (k)
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !c;
      3'd3: return c;
      3'd4: return n;
      3'd5: return n == v;
      3'd6: return n != v;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] model_pc(input bit tk, input logic [15:0] pc,
                                           input logic [9:0] o);
    int words = o[9] ? int'(o) - 1024 : int'(o);
    int base  = int'(pc) & 32'hFFFE;
    if (!tk) return 16'(base);
    return 16'(base + 2 * words);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] pc, input logic [2:0] k, input logic [9:0] o,
                       input logic c, z, n, v);
    @(posedge clk);
    pc_in = pc; cond_in = k; ofs_in = o;
    flag_c = c; flag_z = z; flag_n = n; flag_v = v;
    @(negedge clk);
  endtask

  task automatic run_case(input string req, input logic [15:0] pc, input logic [2:0] k,
                          input logic [9:0] o, input logic c, z, n, v);
    bit tk;
    apply(pc, k, o, c, z, n, v);
    tk = model_take(k, c, z, n, v);
    check({req, " take"}, 32'(take_o), 32'(tk));
    check({req, " next_pc"}, 32'(next_pc_o), 32'(model_pc(tk, pc, o)));
  endtask

  task automatic t_reset();
    @(negedge clk);
    // zero inputs: selector 0 with Z=0 is taken, offset 0 -> PC 0
    check("R2 reset take", 32'(take_o), 32'd1);
    check("R7 reset next_pc", 32'(next_pc_o), 32'd0);
  endtask

  task automatic t_carry();
    for (int c = 0; c < 2; c++) begin
      run_case("R1 carry set", 16'h1000, 3'd3, 10'd4, c[0], 1, 0, 0);
      run_case("R1 carry clear", 16'h1000, 3'd2, 10'd4, c[0], 0, 1, 1);
    end
  endtask

  task automatic t_zero();
    for (int z = 0; z < 2; z++) begin
      run_case("R2 zero set", 16'h2000, 3'd1, 10'd8, 1, z[0], 0, 0);
      run_case("R2 zero clear", 16'h2000, 3'd0, 10'd8, 0, z[0], 1, 0);
    end
  endtask

  task automatic t_neg();
    for (int n = 0; n < 2; n++)
      run_case("R3 negative", 16'h3000, 3'd4, 10'h3F0, 1, 1, n[0], 0);
  endtask

  task automatic t_signed();
    for (int nv = 0; nv < 4; nv++) begin
      run_case("R4 ge", 16'h4000, 3'd5, 10'd20, 0, 0, nv[1], nv[0]);
      run_case("R4 lt", 16'h4000, 3'd6, 10'd20, 1, 1, nv[1], nv[0]);
    end
  endtask

  task automatic t_always();
    for (int f = 0; f < 16; f += 5)
      run_case("R5 always", 16'h5000, 3'd7, 10'd3, f[3], f[2], f[1], f[0]);
  endtask

  task automatic t_target();
    run_case("R6 forward", 16'h8000, 3'd7, 10'd100, 0, 0, 0, 0);
    run_case("R6 backward", 16'h8000, 3'd7, 10'h3FF, 0, 0, 0, 0);
    check("R6 backward literal", 32'(next_pc_o), 32'h7FFE);
  endtask

  task automatic t_fallthru();
    run_case("R7 not taken", 16'h9A42, 3'd1, 10'd50, 0, 0, 0, 0);
    check("R7 literal", 32'(next_pc_o), 32'h9A42);
  endtask

  task automatic t_align();
    run_case("R8 odd pc not taken", 16'h1235, 3'd3, 10'd2, 0, 0, 0, 0);
    check("R8 lsb", 32'(next_pc_o[0]), 32'd0);
    run_case("R8 odd pc taken", 16'h1235, 3'd7, 10'd2, 0, 0, 0, 0);
    check("R8 lsb taken", 32'(next_pc_o[0]), 32'd0);
  endtask

  task automatic t_extremes();
    run_case("R9 min offset", 16'h4000, 3'd7, 10'h200, 0, 0, 0, 0);
    check("R9 min literal", 32'(next_pc_o), 32'h3C00);
    run_case("R9 max offset", 16'h4000, 3'd7, 10'h1FF, 0, 0, 0, 0);
    check("R9 max literal", 32'(next_pc_o), 32'h43FE);
    run_case("R9 wrap high", 16'hFFF0, 3'd7, 10'd16, 0, 0, 0, 0);
    check("R9 wrap high literal", 32'(next_pc_o), 32'h0010);
    run_case("R9 wrap low", 16'h0004, 3'd7, 10'h3FC, 0, 0, 0, 0);
    check("R9 wrap low literal", 32'(next_pc_o), 32'hFFFC);
  endtask

  task automatic t_comb();
    apply(16'h6000, 3'd3, 10'd1, 0, 0, 0, 0);
    #1;
    flag_c = 1'b1;
    #1;
    check("R10 take same cycle", 32'(take_o), 32'd1);
    check("R10 next_pc same cycle", 32'(next_pc_o), 32'h6002);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_carry();
        t_zero();
        t_neg();
        t_signed();
        t_always();
        t_target();
        t_fallthru();
        t_align();
        t_extremes();
        t_comb();
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule